// File: doc/BRIEF.md
# Bridge Gate Fault Supervisor

This block sits between the digital comparator outputs of a two-phase (full-bridge) gate driver and its four gate stages. For every phase it takes a high-side and a low-side turn-on command and produces the effective, registered gate enables. It forces gates off where the fault policy requires it. It merges over-temperature, gate-supply undervoltage, drain-source overvoltage and bootstrap undervoltage into one active-high fault flag. It also produces the enable for the open-drain pull-down on the fault pin.

Each fault class follows its own rule. Over-temperature only reports. Supply undervoltage forces every gate off while it lasts. A drain-source overvoltage is only reported while its gate is on and its turn-on blanking window has ended. A bootstrap shortfall latches per phase and keeps that high-side gate off. The latch releases when the high-side command is dropped or when the fault pin is seen held low from outside. While the pin is held low, the bootstrap monitor is out of action.

Top module: `gfm_top`

## Requirements
- R1: During and right after reset, all gate enables are 0, the fault flag is 0 and the pull-down enable is 1.
- R2: Gate enables follow the commands with one clock of latency. The gates are indexed per phase p as gate 2p = low side and gate 2p+1 = high side.
- R3: When both commands of a phase are high, both gates of that phase are off. The other phase is unaffected.
- R4: Over-temperature raises the fault flag one clock later and disables no gate. The flag clears when the input drops.
- R5: Gate-supply undervoltage raises the fault flag and forces all four gates off one clock later. It is not latched.
- R6: A high-side turn-on is refused when its turn-on-level comparator is 0. The refusal raises the fault flag.
- R7: If the hold-level comparator goes to 0 while a high side is on, that gate is forced off and the flag is raised. All other gates keep following their commands.
- R8: A bootstrap fault stays latched (gate off, flag high) even after the bootstrap recovers. It clears only when the high-side command is removed or the fault pin is sensed held low.
- R9: While the fault pin is sensed held low, the bootstrap monitor neither forces a gate off nor raises the flag. Undervoltage and the other actions still apply.
- R10: A drain-source overvoltage counts only while that gate is on. It never disables a gate, and the flag clears one clock after the comparator drops.
- R11: After each rising edge of a gate's effective on state, its drain-source fault is ignored for BLANK_CYC clocks. With the comparator held high from turn-on, the flag rises BLANK_CYC+2 clocks after the command.
- R12: The monitor mode code selects the drain-source comparator: 2'b00 ignores all drain-source faults, 2'b01 uses the external-threshold comparator, and 2'b1x uses the internal-threshold comparator.
- R13: The pull-down enable is always the inverse of the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hs | input | NPH | High-side turn-on command per phase |
| cmd_ls | input | NPH | Low-side turn-on command per phase |
| ot_trip | input | 1 | Over-temperature comparator, 1 = hot |
| vreg_uv | input | 1 | Gate-supply undervoltage, 1 = low |
| boot_ok_on | input | NPH | Bootstrap above turn-on level, per phase |
| boot_ok_hold | input | NPH | Bootstrap above hold level, per phase |
| pin_held_low | input | 1 | Fault pin sensed forced low from outside |
| vds_mode | input | 2 | Drain-source monitor mode code |
| vds_ext_over | input | 2*NPH | Drain-source over external threshold, per gate |
| vds_int_over | input | 2*NPH | Drain-source over internal threshold, per gate |
| hs_drive | output | NPH | Effective high-side gate enable |
| ls_drive | output | NPH | Effective low-side gate enable |
| fault | output | 1 | Combined fault flag, active high |
| od_pull_en | output | 1 | Fault-pin pull-down enable |

## Verification
A vector table sets clean command patterns (single gates, opposite diagonals, both commands in one phase). It crosses each pattern with over-temperature, undervoltage, a turn-on-level shortfall and a hold-level shortfall, with the fault pin free and held low. This separates the faults that only report from those that disable all gates or a single gate. Directed sequences then hold a bootstrap latch across recovery and release it by each of its two routes. They time the drain-source blanking window edge to edge, and they feed over-threshold signals on idle gates and under each mode code, which shows which comparator is heeded.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic [1:0] {
        VDS_IGNORE = 2'b00,
        VDS_EXT    = 2'b01,
        VDS_INT    = 2'b10,
        VDS_INT2   = 2'b11
    } vds_mode_e;

    // Pick the comparator that the current mode listens to
    function automatic logic vds_pick(input logic [1:0] mode,
                                      input logic ext_over,
                                      input logic int_over);
        logic r;
        case (mode)
            2'b00:   r = 1'b0;
            2'b01:   r = ext_over;
            default: r = int_over;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gfm_blank_timer.sv
module gfm_blank_timer #(
    parameter int BLANK_CYC = 8,
    localparam int CW = $clog2(BLANK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_next,
    input  logic on_now,
    output logic blanking
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          start;

    always_comb begin
        start = on_next & ~on_now;
        if (start)
            cnt_d = CW'(BLANK_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign blanking = (cnt_q != '0);

    // R11: window restarts at full length on each turn-on
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (on_next && !on_now) |=> (cnt_q == CW'(BLANK_CYC)));
endmodule

// File: rtl/gfm_boot_guard.sv
module gfm_boot_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic cmd_hs,
    input  logic mon_off,
    input  logic ok_on,
    input  logic ok_hold,
    output logic hs_next,
    output logic hs_on,
    output logic latched
);
    typedef struct packed {
        logic hs;
        logic lat;
    } bg_state_t;

    bg_state_t s_d, s_q;
    logic refuse, drop;

    always_comb begin
        refuse = want & ~s_q.hs & ~ok_on;
        drop   = want &  s_q.hs & ~ok_hold;
        s_d    = s_q;
        if (!cmd_hs || mon_off)
            s_d.lat = 1'b0;
        else
            s_d.lat = s_q.lat | refuse | drop;
        s_d.hs = want & ~s_d.lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hs_next = s_d.hs;
    assign hs_on   = s_q.hs;
    assign latched = s_q.lat;

    // R6: refused turn-on keeps the gate off
    a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !s_q.hs && !ok_on && !mon_off) |=> !s_q.hs);
    // R8: latched fault holds the gate off while the command stays
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lat && cmd_hs && !mon_off) |=> !s_q.hs);
    // R9: with the pin held low the monitor never blocks
    a_r9_mon_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_off && want) |=> s_q.hs);
endmodule

// File: rtl/gfm_top.sv
module gfm_top #(
    parameter int NPH       = 2,
    parameter int BLANK_CYC = 8,
    localparam int NG = 2 * NPH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPH-1:0]  cmd_hs,
    input  logic [NPH-1:0]  cmd_ls,
    input  logic            ot_trip,
    input  logic            vreg_uv,
    input  logic [NPH-1:0]  boot_ok_on,
    input  logic [NPH-1:0]  boot_ok_hold,
    input  logic            pin_held_low,
    input  logic [1:0]      vds_mode,
    input  logic [NG-1:0]   vds_ext_over,
    input  logic [NG-1:0]   vds_int_over,
    output logic [NPH-1:0]  hs_drive,
    output logic [NPH-1:0]  ls_drive,
    output logic            fault,
    output logic            od_pull_en
);
    import gfm_pkg::*;

    typedef struct packed {
        logic [NPH-1:0] ls;
        logic           flt;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NPH-1:0] hs_want, hs_next, hs_now, boot_lat;
    logic [NG-1:0]  on_next, on_now, blank, vds_hit;

    // Per-phase bootstrap supervision
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign hs_want[p] = cmd_hs[p] & ~cmd_ls[p] & ~vreg_uv;

        gfm_boot_guard u_boot (
            .clk     (clk),
            .rst_n   (rst_n),
            .want    (hs_want[p]),
            .cmd_hs  (cmd_hs[p]),
            .mon_off (pin_held_low),
            .ok_on   (boot_ok_on[p]),
            .ok_hold (boot_ok_hold[p]),
            .hs_next (hs_next[p]),
            .hs_on   (hs_now[p]),
            .latched (boot_lat[p])
        );

        assign on_next[2*p]   = st_d.ls[p];
        assign on_now[2*p]    = st_q.ls[p];
        assign on_next[2*p+1] = hs_next[p];
        assign on_now[2*p+1]  = hs_now[p];
    end

    // Per-gate blanking and drain-source qualification
    for (genvar g = 0; g < NG; g++) begin : g_gate
        gfm_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk      (clk),
            .rst_n    (rst_n),
            .on_next  (on_next[g]),
            .on_now   (on_now[g]),
            .blanking (blank[g])
        );
        assign vds_hit[g] = on_now[g] & ~blank[g] &
                            vds_pick(vds_mode, vds_ext_over[g], vds_int_over[g]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.ls  = cmd_ls & ~cmd_hs & {NPH{~vreg_uv}};
        st_d.flt = ot_trip | vreg_uv | (|vds_hit) |
                   ((|boot_lat) & ~pin_held_low);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_drive   = hs_now;
    assign ls_drive   = st_q.ls;
    assign fault      = st_q.flt;
    assign od_pull_en = ~st_q.flt;

    // R5: undervoltage switches every gate off
    a_r5_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_uv |=> (hs_drive == '0 && ls_drive == '0));
    // R4: over-temperature always reaches the flag
    a_r4_ot_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> fault);
    // R3: both commands in a phase give no drive at all
    for (genvar p = 0; p < NPH; p++) begin : g_chk
        a_r3_lockout: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_hs[p] && cmd_ls[p]) |=> (!hs_drive[p] && !ls_drive[p]));
    end
    // R13: pull-down is off exactly when a fault is shown
    a_r13_od: assert property (@(posedge clk) disable iff (!rst_n)
        od_pull_en != fault);
endmodule

// File: tb/gfm_top_tb.sv
module gfm_top_tb;
    localparam int NPH = 2;
    localparam int NG  = 4;
    localparam int BC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPH-1:0] cmd_hs = '0, cmd_ls = '0, bon = '0, bhold = '0;
    logic ot = 1'b0, uv = 1'b0, pl = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [NG-1:0] vext = '0, vint = '0;
    logic [NPH-1:0] hs_drive, ls_drive;
    logic fault, od_pull_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    gfm_top #(.NPH(NPH), .BLANK_CYC(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_hs(cmd_hs), .cmd_ls(cmd_ls),
        .ot_trip(ot), .vreg_uv(uv), .boot_ok_on(bon), .boot_ok_hold(bhold),
        .pin_held_low(pl), .vds_mode(mode), .vds_ext_over(vext),
        .vds_int_over(vint), .hs_drive(hs_drive), .ls_drive(ls_drive),
        .fault(fault), .od_pull_en(od_pull_en)
    );

    // {hs[1:0], ls[1:0], ot, uv, bon[1:0], bhold[1:0], pl, exp_hs[1:0], exp_ls[1:0], exp_flt}
    localparam logic [15:0] VEC [13] = '{
        16'b01_00_0_0_11_11_0_01_00_0, // R2 single high side
        16'b00_11_0_0_11_11_0_00_11_0, // R2 both low sides
        16'b11_11_0_0_11_11_0_00_00_0, // R3 both commands per phase
        16'b10_01_0_0_11_11_0_10_01_0, // R2 diagonal
        16'b01_10_1_0_11_11_0_01_10_1, // R4 over-temperature
        16'b01_10_0_1_11_11_0_00_00_1, // R5 undervoltage
        16'b01_00_0_0_10_11_0_00_00_1, // R6 refusal
        16'b11_00_0_0_10_11_0_10_00_1, // R7 other phase unaffected
        16'b01_00_0_0_10_11_1_01_00_0, // R9 pin low bypasses monitor
        16'b01_00_0_1_11_11_1_00_00_1, // R9 undervoltage still acts
        16'b01_00_0_0_11_10_0_00_00_1, // R7 hold drop phase 0
        16'b10_00_0_0_11_01_0_00_00_1, // R7 hold drop phase 1
        16'b00_01_1_0_00_00_0_00_01_1  // R4 no gate disabled
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        cmd_hs = '0; cmd_ls = '0; ot = 0; uv = 0; bon = '0; bhold = '0;
        pl = 0; vext = '0; vint = '0; mode = 2'b00;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        tick(2);
        // R1 reset state
        chk("R1 gates", {4'b0, hs_drive, ls_drive}, 8'h00);
        chk("R1 flag", {6'b0, fault, od_pull_en}, 8'h01);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", {3'b0, hs_drive, ls_drive, fault}, 8'h00);

        for (int i = 0; i < 13; i++) begin
            idle();
            tick(1);
            {cmd_hs, cmd_ls, ot, uv, bon, bhold, pl} = VEC[i][15:5];
            tick(3);
            chk($sformatf("table %0d", i), {3'b0, hs_drive, ls_drive, fault},
                {3'b0, VEC[i][4:0]});
            chk("R13 pull-down", {7'b0, od_pull_en}, {7'b0, ~VEC[i][0]});
        end

        // R8 latch held across recovery, released by removing the command
        idle(); tick(1);
        bon = 2'b11; bhold = 2'b10; cmd_hs = 2'b01;
        tick(3);
        bhold = 2'b11;
        tick(3);
        chk("R8 held", {6'b0, hs_drive[0], fault}, 8'h01);
        cmd_hs = 2'b00;
        tick(2);
        chk("R8 cleared by command", {7'b0, fault}, 8'h00);
        cmd_hs = 2'b01;
        tick(1);
        chk("R8 rearm", {7'b0, hs_drive[0]}, 8'h01);

        // R8 release through pin held low
        bhold = 2'b10;
        tick(3);
        chk("R8 latched again", {6'b0, hs_drive[0], fault}, 8'h01);
        bhold = 2'b11; pl = 1;
        tick(2);
        chk("R8 pin release", {6'b0, hs_drive[0], fault}, 8'h02);
        pl = 0;
        tick(2);
        chk("R8 stays on", {6'b0, hs_drive[0], fault}, 8'h02);

        // R11 blanking window
        idle(); tick(2);
        mode = 2'b01; vext = 4'b0001; cmd_ls = 2'b01;
        tick(BC + 1);
        chk("R11 inside window", {7'b0, fault}, 8'h00);
        tick(1);
        chk("R11 after window", {6'b0, ls_drive[0], fault}, 8'h03);
        // R10 clears one clock after comparator drops
        vext = 4'b0000;
        tick(1);
        chk("R10 clear", {7'b0, fault}, 8'h00);
        // R11 restart on next turn-on
        vext = 4'b0001; cmd_ls = 2'b00;
        tick(2);
        chk("R10 gate off", {7'b0, fault}, 8'h00);
        cmd_ls = 2'b01;
        tick(BC + 1);
        chk("R11 restart", {7'b0, fault}, 8'h00);
        tick(1);
        chk("R11 restart end", {7'b0, fault}, 8'h01);

        // R10 over-threshold on a gate not commanded
        vext = 4'b0010;
        tick(BC + 3);
        chk("R10 idle gate", {7'b0, fault}, 8'h00);

        // R12 mode codes
        vext = 4'b0001; mode = 2'b00;
        tick(2);
        chk("R12 ignore", {7'b0, fault}, 8'h00);
        mode = 2'b10;
        tick(2);
        chk("R12 internal ignores external", {7'b0, fault}, 8'h00);
        vint = 4'b0001;
        tick(1);
        chk("R12 internal", {7'b0, fault}, 8'h01);
        mode = 2'b11; vint = 4'b0000;
        tick(1);
        chk("R12 code 11", {7'b0, fault}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule